// File: doc/BRIEF.md
# Fast Ethernet Transmit Line Encoder

This block turns the nibble stream a MAC presents for 100 Mb/s twisted-pair transmission into a three-level line symbol per 125 MHz clock. It runs entirely in the 125 MHz domain. A nibble strobe marks every fifth cycle, which is one 25 MHz nibble period. On each strobe the block reads the transmit-enable flag and the data nibble. It picks a 5-bit code group: a data code, a start-of-stream pair, an end-of-stream pair or idle. It then shifts the code group out one bit per cycle.

Each serial bit is XORed with a free-running 11-bit linear feedback sequence to spread the line spectrum. The result is converted to NRZI and then mapped onto the three MLT3 levels. The output is a 2-bit signed code that a downstream analog driver would consume. An output-valid flag rises once the first code group has reached the output. A synchronous active-low reset puts every stage back to idle transmission.

Top module: `fe_tx_line_encoder`

## Requirements
- R1: While reset is asserted at a clock edge, the block drives `mlt3_o` = 2'b00 and `mlt3_vld_o` = 0 after that edge. It clears the framing state, the serial stage, the NRZI level and the MLT3 phase, and reloads the scrambler with the seed parameter.
- R2: A nibble taken in a data slot is sent as its 5-bit data code group, first bit first. The codes for nibbles 0..F are 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R3: A strobe that finds the encoder idle with transmit-enable high sends J (11000) in place of that nibble. The next strobe sends K (10001), whatever transmit-enable and the nibble are on it. Data slots follow.
- R4: The first strobe in a data slot with transmit-enable low sends T (01101), and the strobe after it sends R (00111). Transmit-enable seen on the R strobe is ignored. The encoder is idle again after R.
- R5: When no frame is in progress, every strobe sends the idle code group 11111. Before the first strobe after reset, the serial stream is all ones.
- R6: Each serial code bit is XORed with b10^b8 of an 11-bit shift register (polynomial x^11 + x^9 + 1). The register shifts left every cycle with that bit fed into b0, and it starts from `SCR_SEED` (11'h5A3 by default) after reset.
- R7: The NRZI level toggles on every scrambled 1 and holds on every scrambled 0.
- R8: The MLT3 output moves one step through the cycle 0, +1, 0, -1 on each NRZI transition and holds otherwise. The levels are encoded 2'b00 = 0, 2'b01 = +1, 2'b11 = -1, and 2'b10 never appears.
- R9: The bit taken from a code group on strobe edge e appears at the output as the MLT3 step made on edge e+3. `mlt3_vld_o` rises on the third edge after the first strobe edge following reset and stays high until the next reset.
- R10: `tx_en_i` and `nib_i` are read only on cycles with `nib_stb_i` high. Changing them on other cycles does not change the line stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 125 MHz line clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nib_stb_i | input | 1 | Nibble strobe, high one cycle in every five |
| tx_en_i | input | 1 | Transmit enable from the MAC side, read on strobe cycles |
| nib_i | input | 4 | Data nibble, read on strobe cycles |
| mlt3_o | output | 2 | Line symbol: 00 = 0, 01 = +1, 11 = -1 |
| mlt3_vld_o | output | 1 | Line symbol is meaningful |

## Verification
The hardest case to reach from the ports is transmit-enable rising again on the strobe that carries R. The encoder must ignore it and fall back to idle rather than starting a new frame. The stimulus schedule reaches this case by raising transmit-enable on exactly that strobe for half of the frames, across frame lengths from one nibble upward. A second hard case is telling a wrong code bit from a wrong scrambler or NRZI step when only MLT3 levels are visible. The bench recovers each scrambled bit from whether the level changed. It then removes its own running copy of the scrambler sequence and compares the result with the code-group bit it scheduled three cycles earlier. The bench also flips `tx_en_i` and drives junk nibbles between strobes, and it resets the block in the middle of a frame.

// File: rtl/fetx_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, code groups, framer states and line-level codes
// for the Fast Ethernet transmit line encoder.
package fetx_pkg;

    localparam int NIB_W  = 4;
    localparam int CG_W   = 5;
    localparam int LFSR_W = 11;

    typedef logic [CG_W-1:0] cg_t;
    typedef logic [1:0]      lvl_t;

    // Control code groups, written in transmission order (MSB goes first)
    localparam cg_t CG_IDLE = 5'b11111;
    localparam cg_t CG_J    = 5'b11000;
    localparam cg_t CG_K    = 5'b10001;
    localparam cg_t CG_T    = 5'b01101;
    localparam cg_t CG_R    = 5'b00111;

    // Three-level line codes
    localparam lvl_t LVL_ZERO = 2'b00;
    localparam lvl_t LVL_POS  = 2'b01;
    localparam lvl_t LVL_NEG  = 2'b11;

    typedef enum logic [1:0] {
        FR_IDLE   = 2'd0,
        FR_SEND_K = 2'd1,
        FR_DATA   = 2'd2,
        FR_SEND_R = 2'd3
    } fr_state_e;

    // Data nibble to 5-bit code group
    function automatic cg_t nib_to_cg(input logic [NIB_W-1:0] nib);
        cg_t c;
        case (nib)
            4'h0: c = 5'b11110;
            4'h1: c = 5'b01001;
            4'h2: c = 5'b10100;
            4'h3: c = 5'b10101;
            4'h4: c = 5'b01010;
            4'h5: c = 5'b01011;
            4'h6: c = 5'b01110;
            4'h7: c = 5'b01111;
            4'h8: c = 5'b10010;
            4'h9: c = 5'b10011;
            4'hA: c = 5'b10110;
            4'hB: c = 5'b10111;
            4'hC: c = 5'b11010;
            4'hD: c = 5'b11011;
            4'hE: c = 5'b11100;
            default: c = 5'b11101;
        endcase
        return c;
    endfunction

    // MLT3 phase (0..3) to line level: 0, +1, 0, -1
    function automatic lvl_t phase_to_lvl(input logic [1:0] ph);
        lvl_t l;
        case (ph)
            2'd1:    l = LVL_POS;
            2'd3:    l = LVL_NEG;
            default: l = LVL_ZERO;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/fetx_framer.sv
`timescale 1ns/1ps
// Framer: chooses the code group for each nibble slot.
// Assumes stb_i is high one cycle in five; tx_en_i and nib_i are only
// looked at when stb_i is high. cg_o is combinational and valid in strobe
// cycles; the state advances only on strobe edges.
module fetx_framer
    import fetx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb_i,
    input  logic             tx_en_i,
    input  logic [NIB_W-1:0] nib_i,
    output cg_t              cg_o
);

    fr_state_e st_q;
    fr_state_e st_d;

    // Next code group and next framing state for the current slot
    always_comb begin
        cg_o = CG_IDLE;
        st_d = st_q;
        case (st_q)
            FR_IDLE: begin
                if (tx_en_i) begin
                    cg_o = CG_J;
                    st_d = FR_SEND_K;
                end
            end
            FR_SEND_K: begin
                cg_o = CG_K;
                st_d = FR_DATA;
            end
            FR_DATA: begin
                if (tx_en_i) begin
                    cg_o = nib_to_cg(nib_i);
                end else begin
                    cg_o = CG_T;
                    st_d = FR_SEND_R;
                end
            end
            FR_SEND_R: begin
                cg_o = CG_R;
                st_d = FR_IDLE;
            end
            default: begin
                cg_o = CG_IDLE;
                st_d = FR_IDLE;
            end
        endcase
    end

    // Framing state register, advanced on strobe edges only
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= FR_IDLE;
        else if (stb_i)
            st_q <= st_d;
    end

    // A J slot is always followed by a K slot (R3)
    assert_j_then_k_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && cg_o == CG_J) |=> (st_q == FR_SEND_K));

    // After R the framer is idle, whatever tx_en did on the R strobe (R4)
    assert_r_then_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && cg_o == CG_R) |=> (st_q == FR_IDLE));

endmodule

// File: rtl/fetx_serializer.sv
`timescale 1ns/1ps
// Serializer: loads a code group on a strobe edge and sends it first bit
// first, one bit per cycle. Ones are shifted in behind it, so the stream
// stays at idle if a strobe is late. Assumes strobes are five cycles apart.
module fetx_serializer
    import fetx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stb_i,
    input  cg_t  cg_i,
    output logic bit_o,
    output logic vld_o
);

    localparam int REM_W = CG_W - 1;

    logic [REM_W-1:0] rem_q;
    logic             bit_q;
    logic             vld_q;

    // Shift register: load on strobe, otherwise shift with ones filling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= 1'b1;
            rem_q <= '1;
        end else if (stb_i) begin
            bit_q <= cg_i[CG_W-1];
            rem_q <= cg_i[REM_W-1:0];
        end else begin
            bit_q <= rem_q[REM_W-1];
            rem_q <= {rem_q[REM_W-2:0], 1'b1};
        end
    end

    // Valid flag: set by the first strobe after reset, then held
    always_ff @(posedge clk) begin
        if (!rst_n)
            vld_q <= 1'b0;
        else if (stb_i)
            vld_q <= 1'b1;
    end

    assign bit_o = bit_q;
    assign vld_o = vld_q;

    // Valid never drops without reset (R9)
    assert_vld_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |=> vld_q);

endmodule

// File: rtl/fetx_scrambler.sv
`timescale 1ns/1ps
// Scrambler: XORs each serial bit with the output of a free-running LFSR
// that steps once per cycle. Assumes a nonzero seed.
module fetx_scrambler
    import fetx_pkg::*;
#(
    parameter int                 TAP_HI = LFSR_W,
    parameter int                 TAP_LO = 9,
    parameter logic [LFSR_W-1:0]  SEED   = 11'h5A3
)(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_i,
    input  logic vld_i,
    output logic bit_o,
    output logic vld_o
);

    logic [LFSR_W-1:0] lfsr_q;
    logic              key;
    logic              bit_q;
    logic              vld_q;

    assign key = lfsr_q[TAP_HI-1] ^ lfsr_q[TAP_LO-1];

    // LFSR advance, one step per cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            lfsr_q <= SEED;
        else
            lfsr_q <= {lfsr_q[LFSR_W-2:0], key};
    end

    // Scrambled bit register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= 1'b0;
            vld_q <= 1'b0;
        end else begin
            bit_q <= bit_i ^ key;
            vld_q <= vld_i;
        end
    end

    assign bit_o = bit_q;
    assign vld_o = vld_q;

    // The sequence must never lock up at zero (R6)
    assert_lfsr_alive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);

endmodule

// File: rtl/fetx_nrzi.sv
`timescale 1ns/1ps
// NRZI stage: toggles the held level on each 1, holds it on each 0.
module fetx_nrzi (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_i,
    input  logic vld_i,
    output logic lvl_o,
    output logic vld_o
);

    logic lvl_q;
    logic vld_q;

    // Level register with toggle-on-one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
            vld_q <= 1'b0;
        end else begin
            lvl_q <= lvl_q ^ bit_i;
            vld_q <= vld_i;
        end
    end

    assign lvl_o = lvl_q;
    assign vld_o = vld_q;

endmodule

// File: rtl/fetx_mlt3.sv
`timescale 1ns/1ps
// MLT3 stage: advances a 2-bit phase on each NRZI transition and drives
// the matching three-level code (00 = 0, 01 = +1, 11 = -1).
module fetx_mlt3
    import fetx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic nrzi_i,
    input  logic vld_i,
    output lvl_t sym_o,
    output logic vld_o
);

    logic [1:0] phase_q;
    logic [1:0] phase_d;
    logic       prev_q;
    logic       edge_seen;
    lvl_t       sym_q;
    logic       vld_q;

    assign edge_seen = nrzi_i ^ prev_q;
    assign phase_d   = phase_q + {1'b0, edge_seen};

    // Phase, previous level and output symbol registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 2'd0;
            prev_q  <= 1'b0;
            sym_q   <= LVL_ZERO;
            vld_q   <= 1'b0;
        end else begin
            phase_q <= phase_d;
            prev_q  <= nrzi_i;
            sym_q   <= phase_to_lvl(phase_d);
            vld_q   <= vld_i;
        end
    end

    assign sym_o = sym_q;
    assign vld_o = vld_q;

    // Only the three legal codes appear (R8)
    assert_legal_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sym_q != 2'b10);

    // From a nonzero level the next level is the same or zero (R8)
    assert_via_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_q != LVL_ZERO) |=> (sym_q == $past(sym_q) || sym_q == LVL_ZERO));

endmodule

// File: rtl/fe_tx_line_encoder.sv
`timescale 1ns/1ps
// Fast Ethernet transmit line encoder, top level.
// Chain: framer -> serializer -> scrambler -> NRZI -> MLT3.
// Assumes nib_stb_i is high one cycle in every five of the 125 MHz clock.
module fe_tx_line_encoder
    import fetx_pkg::*;
#(
    parameter logic [10:0] SCR_SEED = 11'h5A3
)(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       nib_stb_i,
    input  logic       tx_en_i,
    input  logic [3:0] nib_i,
    output logic [1:0] mlt3_o,
    output logic       mlt3_vld_o
);

    cg_t  cg;
    logic ser_bit, ser_vld;
    logic scr_bit, scr_vld;
    logic nrz_lvl, nrz_vld;

    fetx_framer u_framer (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb_i   (nib_stb_i),
        .tx_en_i (tx_en_i),
        .nib_i   (nib_i),
        .cg_o    (cg)
    );

    fetx_serializer u_ser (
        .clk   (clk),
        .rst_n (rst_n),
        .stb_i (nib_stb_i),
        .cg_i  (cg),
        .bit_o (ser_bit),
        .vld_o (ser_vld)
    );

    fetx_scrambler #(
        .SEED (SCR_SEED)
    ) u_scr (
        .clk   (clk),
        .rst_n (rst_n),
        .bit_i (ser_bit),
        .vld_i (ser_vld),
        .bit_o (scr_bit),
        .vld_o (scr_vld)
    );

    fetx_nrzi u_nrzi (
        .clk   (clk),
        .rst_n (rst_n),
        .bit_i (scr_bit),
        .vld_i (scr_vld),
        .lvl_o (nrz_lvl),
        .vld_o (nrz_vld)
    );

    fetx_mlt3 u_mlt3 (
        .clk    (clk),
        .rst_n  (rst_n),
        .nrzi_i (nrz_lvl),
        .vld_i  (nrz_vld),
        .sym_o  (mlt3_o),
        .vld_o  (mlt3_vld_o)
    );

    // A scrambled 1 shows up as a line step two edges later (R7, R8)
    assert_one_steps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        scr_bit |=> ##1 (mlt3_o != $past(mlt3_o)));

    // A scrambled 0 leaves the line level alone (R7)
    assert_zero_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !scr_bit |=> ##1 $stable(mlt3_o));

endmodule

// File: tb/fe_tx_line_encoder_tb.sv
`timescale 1ns/1ps
module fe_tx_line_encoder_tb;

    localparam logic [10:0] SEED   = 11'h5A3;
    localparam int          T_END  = 3100;
    localparam int          T_RST2 = 1500;
    localparam logic [79:0] DTBL = {5'b11110, 5'b01001, 5'b10100, 5'b10101,
                                    5'b01010, 5'b01011, 5'b01110, 5'b01111,
                                    5'b10010, 5'b10011, 5'b10110, 5'b10111,
                                    5'b11010, 5'b11011, 5'b11100, 5'b11101};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nib_stb = 1'b0;
    logic       tx_en = 1'b0;
    logic [3:0] nib = 4'h0;
    logic [1:0] mlt3;
    logic       mlt3_vld;

    int checks = 0;
    int fails  = 0;
    int tcyc   = 0;
    int cyc    = 0;
    int nstb   = 0;
    int bst    = 0;
    bit done   = 0;

    logic [10:0] blfsr;
    bit          keyh [64];
    bit          expb [64];
    int          tagh [64];
    logic [1:0]  prev_obs;
    logic [1:0]  last_nz;

    always #2.5 clk = ~clk;

    fe_tx_line_encoder #(.SCR_SEED(SEED)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .nib_stb_i  (nib_stb),
        .tx_en_i    (tx_en),
        .nib_i      (nib),
        .mlt3_o     (mlt3),
        .mlt3_vld_o (mlt3_vld)
    );

    function automatic string tag_name(input int c);
        case (c)
            2:       return "R2";
            3:       return "R3";
            4:       return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, tcyc, act, exp);
        end
    endtask

    // Bench copy of the scrambler sequence, one step per edge out of reset (R6)
    always @(posedge clk) begin
        if (!rst_n) begin
            cyc     = 0;
            blfsr   = SEED;
            keyh[0] = blfsr[10] ^ blfsr[8];
        end else begin
            cyc   = cyc + 1;
            blfsr = {blfsr[9:0], blfsr[10] ^ blfsr[8]};
            keyh[cyc % 64] = blfsr[10] ^ blfsr[8];
        end
    end

    // Checks after each edge, then drive for the next edge
    always @(negedge clk) begin
        logic [4:0] cg;
        int         tg;
        bit         en_n;
        logic [3:0] nib_n;
        int         p, q, len, rslot, e;
        bit         obs, code;
        logic [1:0] exp_l;
        tcyc++;
        if (!rst_n) begin
            // R1: reset state at the ports
            check(mlt3 == 2'b00, "R1 level", mlt3, 0);
            check(mlt3_vld == 1'b0, "R1 valid", mlt3_vld, 0);
            prev_obs = 2'b00;
            last_nz  = 2'b11;
            expb[0]  = 1'b1;
            tagh[0]  = 5;
        end else begin
            // R9: valid from the third edge after strobe edge 1
            check(mlt3_vld == (cyc >= 4), "R9 valid", mlt3_vld, (cyc >= 4));
            // R8: legal codes and stepping order
            check(mlt3 != 2'b10, "R8 code", mlt3, 0);
            if (mlt3 != prev_obs) begin
                if (prev_obs == 2'b00) begin
                    exp_l = (last_nz == 2'b01) ? 2'b11 : 2'b01;
                    check(mlt3 == exp_l, "R8 step", mlt3, exp_l);
                    last_nz = mlt3;
                end else begin
                    check(mlt3 == 2'b00, "R8 step", mlt3, 0);
                end
            end
            // R2..R5 through R6, R7, R9: recovered code bit three edges on
            if (cyc >= 3) begin
                obs  = (mlt3 != prev_obs);
                code = obs ^ keyh[(cyc - 3) % 64];
                check(code == expb[(cyc - 3) % 64],
                      {tag_name(tagh[(cyc - 3) % 64]), " bit (R6 R7 R9)"},
                      code, expb[(cyc - 3) % 64]);
            end
            prev_obs = mlt3;
        end

        // Drive next cycle
        rst_n = !(tcyc < 4 || (tcyc >= T_RST2 && tcyc < T_RST2 + 4));
        if (!rst_n) begin
            nib_stb = 1'b0;
            nstb    = 0;
            bst     = 0;
            tx_en   = ~tx_en;
        end else if ((cyc + 1) % 5 == 1) begin
            e     = cyc + 1;
            p     = nstb % 37;
            q     = nstb / 37;
            len   = q % 20 + 1;
            rslot = (len == 1) ? 6 : 4 + len;
            en_n  = (p >= 3 && p < 3 + len) || ((q % 2 == 0) && p == rslot);
            nib_n = 4'((nstb * 7 + nstb / 16) % 16);
            case (bst)
                0: if (en_n) begin cg = 5'b11000; bst = 1; tg = 3; end
                   else begin cg = 5'b11111; tg = 5; end
                1: begin cg = 5'b10001; bst = 2; tg = 3; end
                2: if (en_n) begin cg = DTBL[(15 - nib_n) * 5 +: 5]; tg = 2; end
                   else begin cg = 5'b01101; bst = 3; tg = 4; end
                default: begin cg = 5'b00111; bst = 0; tg = 4; end
            endcase
            for (int k = 0; k < 5; k++) begin
                expb[(e + k) % 64] = cg[4 - k];
                tagh[(e + k) % 64] = tg;
            end
            nib_stb = 1'b1;
            tx_en   = en_n;
            nib     = nib_n;
            nstb++;
        end else begin
            // R10: junk on tx_en and nibble between strobes
            nib_stb = 1'b0;
            tx_en   = ~tx_en;
            nib     = nib + 4'd5;
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", tcyc, T_END);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        wait (tcyc >= T_END);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule